// File: doc/BRIEF.md
# Conditional Branch Condition Evaluator

This block decides whether a conditional jump is taken. It receives a 4-bit condition code, the five arithmetic status flags (carry, parity, zero, sign, overflow), the value of the count register and a select that asks for a count-register-zero test. It returns a single taken/not-taken bit. Target address computation and instruction fetch are handled elsewhere.

The condition code is split into two fields. Bits 3:1 pick one of eight base conditions, and bit 0 inverts the sense of that condition. Every pair of alias mnemonics maps to one code, so "equal" and "zero" share an encoding, as do "carry" and "below". Signed orderings are derived from the relation between the sign and overflow flags. When the count-zero select is high, the flags and the code play no part: the jump is taken exactly when the whole count register is zero.

The decision logic is combinational. Its result is captured in one output register, which has a synchronous active-low reset, so the decision appears one clock after the inputs are presented.

Top module: `cc_branch_eval`

## Requirements
- R1: While rst_n is low at a rising edge, branch_taken is 0 after that edge, whatever the other inputs are.
- R2: With use_count_zero low, codes 2k and 2k+1 always give opposite results for the same flags; bit 0 of cond_code is the inversion bit.
- R3: Code 4 (equal, alias zero) is taken when flag_zero is 1. Code 5 (not equal, alias not zero) is taken when flag_zero is 0.
- R4: Code 12 (less) is taken when flag_sign differs from flag_overflow. Code 13 (greater-or-equal, alias not less) is taken when they are equal.
- R5: Code 14 (less-or-equal) is taken when flag_zero is 1 or flag_sign differs from flag_overflow. Code 15 (greater) is taken when flag_zero is 0 and flag_sign equals flag_overflow.
- R6: Code 6 (below-or-equal) is taken when flag_carry or flag_zero is 1. Code 7 (above) is taken when both are 0.
- R7: Codes 0 and 1 test overflow set and clear. Codes 2 and 3 (carry, alias below) test carry set and clear. Codes 8 and 9 test sign set and clear. Codes 10 and 11 test parity set and clear.
- R8: With use_count_zero high, the result is 1 exactly when all 32 bits of count_value are 0. cond_code and every flag have no effect.
- R9: branch_taken reflects the inputs sampled at the preceding rising edge of clk, which is a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cond_code | input | 4 | Condition code: bits 3:1 select the base condition, bit 0 inverts it |
| use_count_zero | input | 1 | Selects the count-register-zero test instead of the flag test |
| flag_carry | input | 1 | Carry flag |
| flag_parity | input | 1 | Parity flag |
| flag_zero | input | 1 | Zero flag |
| flag_sign | input | 1 | Sign flag |
| flag_overflow | input | 1 | Overflow flag |
| count_value | input | 32 | Count register value |
| branch_taken | output | 1 | Registered taken decision |

## Verification
The case hardest to reach from the ports is a count register that is non-zero in only one bit, especially a high-order bit, while the flags and the code would by themselves give a taken result. Such a value exposes a zero detector that looks at only part of the register. The stimulus first sweeps all 32 flag combinations for each of the 16 codes. It then holds the count-zero select high and walks a single set bit across every position of count_value, with flags and codes chosen so that the flag path would have answered 1. An all-zero count is also driven under several flag and code patterns, to confirm that the select takes priority in both directions.

// File: rtl/cc_pkg.sv
// Package cc_pkg: shared types for the branch condition evaluator.
// Assumes the base condition index is bits 3:1 of the 4-bit code.
package cc_pkg;
    localparam int CODE_W = 4;
    localparam int BASE_N = 1 << (CODE_W - 1);

    // Base conditions, indexed by code bits 3:1
    typedef enum logic [CODE_W-2:0] {
        BC_OVF     = 3'd0,
        BC_CARRY   = 3'd1,
        BC_ZERO    = 3'd2,
        BC_BELOW_EQ= 3'd3,
        BC_SIGN    = 3'd4,
        BC_PARITY  = 3'd5,
        BC_LESS    = 3'd6,
        BC_LESS_EQ = 3'd7
    } base_cond_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic par;
        logic cry;
    } flags_t;

    // Evaluate one base condition against the flags
    function automatic logic eval_base(input base_cond_e sel, input flags_t f);
        logic lt;
        lt = f.sgn ^ f.ovf;
        case (sel)
            BC_OVF:      eval_base = f.ovf;
            BC_CARRY:    eval_base = f.cry;
            BC_ZERO:     eval_base = f.zro;
            BC_BELOW_EQ: eval_base = f.cry | f.zro;
            BC_SIGN:     eval_base = f.sgn;
            BC_PARITY:   eval_base = f.par;
            BC_LESS:     eval_base = lt;
            default:     eval_base = lt | f.zro;
        endcase
    endfunction
endpackage

// File: rtl/cc_base_eval.sv
// Module cc_base_eval: computes all base conditions in parallel as a vector.
// Assumes the flags are stable within the cycle; purely combinational.
module cc_base_eval
    import cc_pkg::*;
(
    input  flags_t            flags,
    output logic [BASE_N-1:0] base_vec
);
    for (genvar gi = 0; gi < BASE_N; gi++) begin : g_base
        // One evaluator per base condition
        always_comb base_vec[gi] = eval_base(base_cond_e'(gi), flags);
    end
endmodule

// File: rtl/cc_sense_select.sv
// Module cc_sense_select: picks a base condition and applies the inversion bit.
// Assumes code bit 0 is the sense bit and the upper bits index base_vec.
module cc_sense_select
    import cc_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [BASE_N-1:0] base_vec,
    output logic              cond_hit
);
    // Select, then invert when bit 0 is set
    always_comb cond_hit = base_vec[code[CODE_W-1:1]] ^ code[0];
endmodule

// File: rtl/cc_count_zero.sv
// Module cc_count_zero: detects an all-zero count register with a chunked
// reduction. Assumes CNT_W is a multiple of CHUNK_W.
module cc_count_zero #(
    parameter int CNT_W   = 32,
    parameter int CHUNK_W = 8
) (
    input  logic [CNT_W-1:0] count,
    output logic             is_zero
);
    localparam int N_CHUNK = CNT_W / CHUNK_W;
    logic [N_CHUNK-1:0] chunk_zero;

    for (genvar gc = 0; gc < N_CHUNK; gc++) begin : g_chunk
        // Per-chunk zero test
        always_comb chunk_zero[gc] = ~|count[gc*CHUNK_W +: CHUNK_W];
    end

    // All chunks must be zero
    always_comb is_zero = &chunk_zero;
endmodule

// File: rtl/cc_branch_eval.sv
// Module cc_branch_eval: top of the branch condition evaluator. Combines the
// flag path and the count-zero path and registers the decision.
// Assumes synchronous active-low reset; one cycle of latency.
module cc_branch_eval
    import cc_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int CHUNK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cond_code,
    input  logic             use_count_zero,
    input  logic             flag_carry,
    input  logic             flag_parity,
    input  logic             flag_zero,
    input  logic             flag_sign,
    input  logic             flag_overflow,
    input  logic [CNT_W-1:0] count_value,
    output logic             branch_taken
);
    flags_t            flags;
    logic [BASE_N-1:0] base_vec;
    logic              flag_hit;
    logic              cnt_zero;
    logic              taken_d;

    // Pack the flag pins into the shared struct
    always_comb flags = '{ovf: flag_overflow, sgn: flag_sign, zro: flag_zero,
                          par: flag_parity, cry: flag_carry};

    cc_base_eval u_base (
        .flags    (flags),
        .base_vec (base_vec)
    );

    cc_sense_select u_sel (
        .code     (cond_code),
        .base_vec (base_vec),
        .cond_hit (flag_hit)
    );

    cc_count_zero #(.CNT_W(CNT_W), .CHUNK_W(CHUNK_W)) u_cz (
        .count   (count_value),
        .is_zero (cnt_zero)
    );

    // The count-zero test overrides the flag test
    always_comb taken_d = use_count_zero ? cnt_zero : flag_hit;

    // Output register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) branch_taken <= 1'b0;
        else        branch_taken <= taken_d;
    end
endmodule

// File: rtl/cc_branch_eval_checker.sv
// Module cc_branch_eval_checker: port-level properties of cc_branch_eval.
// Assumes the one-cycle latency of the output register.
module cc_branch_eval_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       cond_code,
    input logic             use_count_zero,
    input logic             flag_carry,
    input logic             flag_parity,
    input logic             flag_zero,
    input logic             flag_sign,
    input logic             flag_overflow,
    input logic [CNT_W-1:0] count_value,
    input logic             branch_taken
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> !branch_taken);

    p_equal_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_count_zero && cond_code == 4'd4) |=> branch_taken == $past(flag_zero));

    p_ge_signed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_count_zero && cond_code == 4'd13)
        |=> branch_taken == ($past(flag_sign) == $past(flag_overflow)));

    p_greater_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_count_zero && cond_code == 4'd15)
        |=> branch_taken == (!$past(flag_zero) && ($past(flag_sign) == $past(flag_overflow))));

    p_above_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_count_zero && cond_code == 4'd7)
        |=> branch_taken == (!$past(flag_carry) && !$past(flag_zero)));

    p_count_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        use_count_zero |=> branch_taken == ($past(count_value) == '0));

    p_parity_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_count_zero && cond_code == 4'd10) |=> branch_taken == $past(flag_parity));
endmodule

bind cc_branch_eval cc_branch_eval_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/cc_branch_eval_bench.sv
module cc_branch_eval_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cond_code = '0;
    logic        use_count_zero = 1'b0;
    logic        flag_carry = 0, flag_parity = 0, flag_zero = 0, flag_sign = 0, flag_overflow = 0;
    logic [31:0] count_value = '0;
    logic        branch_taken;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    cc_branch_eval u_cc_branch_eval (.*);

    // Behavioural reference: mnemonic-by-mnemonic table
    function automatic bit ref_taken(input logic [3:0] c, input bit sel,
                                     input logic [4:0] f, input logic [31:0] cnt);
        bit cf, pf, zf, sf, of_;
        {of_, sf, zf, pf, cf} = f;
        if (sel) return (cnt == 0);
        case (c)
            4'd0:  return of_;
            4'd1:  return !of_;
            4'd2:  return cf;
            4'd3:  return !cf;
            4'd4:  return zf;
            4'd5:  return !zf;
            4'd6:  return cf || zf;
            4'd7:  return !cf && !zf;
            4'd8:  return sf;
            4'd9:  return !sf;
            4'd10: return pf;
            4'd11: return !pf;
            4'd12: return sf != of_;
            4'd13: return sf == of_;
            4'd14: return zf || (sf != of_);
            default: return !zf && (sf == of_);
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] c, input bit sel);
        if (sel) return "R8";
        case (c)
            4'd4, 4'd5:   return "R3";
            4'd12, 4'd13: return "R4";
            4'd14, 4'd15: return "R5";
            4'd6, 4'd7:   return "R6";
            default:      return "R7";
        endcase
    endfunction

    task automatic check(input string req, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Drive one vector at the falling edge, check it at the next falling edge
    task automatic apply(input logic [3:0] c, input bit sel, input logic [4:0] f,
                         input logic [31:0] cnt, input string req);
        cond_code = c; use_count_zero = sel; count_value = cnt;
        {flag_overflow, flag_sign, flag_zero, flag_parity, flag_carry} = f;
        exp_q.push_back(ref_taken(c, sel, f, cnt));
        tag_q.push_back(req);
        @(negedge clk);
        check(tag_q.pop_front(), branch_taken, exp_q.pop_front());
    endtask

    initial begin
        bit pair_a;
        // R1: reset holds output low even with a taken-looking input
        cond_code = 4'd4; flag_zero = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", branch_taken, 1'b0);
        rst_n = 1'b1;

        // Full sweep: every code against every flag combination
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 32; f++)
                apply(4'(c), 1'b0, 5'(f), 32'hDEAD_BEEF, req_of(4'(c), 1'b0));

        // R2: paired codes give opposite results
        for (int c = 0; c < 16; c += 2)
            for (int f = 0; f < 32; f += 7) begin
                apply(4'(c), 1'b0, 5'(f), 32'd1, "R2");
                pair_a = branch_taken;
                apply(4'(c + 1), 1'b0, 5'(f), 32'd1, "R2");
                check("R2", branch_taken, !pair_a);
            end

        // R8: walking single set bit with flags that would say taken
        for (int b = 0; b < 32; b++)
            apply(4'd4, 1'b1, 5'b00100, 32'd1 << b, "R8");
        for (int c = 0; c < 16; c++)
            apply(4'(c), 1'b1, 5'(c * 3), 32'd0, "R8");
        apply(4'd5, 1'b1, 5'b00100, 32'hFFFF_FFFF, "R8");

        // R9: output follows the previous edge's inputs
        apply(4'd4, 1'b0, 5'b00100, 32'd0, "R9");
        cond_code = 4'd5;
        #5;
        check("R9", branch_taken, 1'b1);
        @(negedge clk);
        check("R9", branch_taken, 1'b0);

        // R1: reset again after activity
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", branch_taken, 1'b0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule